// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked request port and an external asynchronous static RAM. The RAM holds 256K words of 16 bits and has an 18-bit address. Its data bus is shared between the two directions. Chip select, output enable, write enable and one enable per byte lane are all active low. The user issues one request at a time over a valid/ready handshake. A request carries an address, write data, a per-lane mask and a direction flag. A read returns its data with a single-cycle valid pulse.

Every strobe, the address and the outgoing data come straight from flops. Each RAM timing minimum (access time, write pulse width, data setup, write cycle time) is turned into whole clock cycles from the clock period. A write word is opened and closed by the byte enables. Write enable stays low across consecutive writes, and output enable stays high for the whole write phase. The data bus here is split into an output vector, a per-lane drive enable and an input vector, and a pad ring merges them outside this block. After every read there is at least one cycle in which neither side drives the bus.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted, and right after reset, every RAM strobe (`ram_ce_n`, `ram_oe_n`, `ram_we_n`, every bit of `ram_be_n`) is high, no lane is driven, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` falls on that edge. It rises again 2 cycles after a write is accepted and 4 cycles after a read is accepted (default timing).
- R3: `req_mask` bit 0 selects the lower lane, data bits 7..0, which maps to `ram_be_n[0]`. Bit 1 selects the upper lane, bits 15..8, which maps to `ram_be_n[1]`. A write stores and drives only the selected lanes. A write with mask 00 leaves the RAM unchanged.
- R4: During each write word the selected byte enables stay low for WR_PULSE consecutive cycles (2 at a 4 ns clock), with chip select and write enable low and output enable high. The lane data is driven and held stable from the start of the word through the cycle after the enables rise.
- R5: The controller drives a data lane only while write enable and chip select are low and output enable is high. It never drives while the RAM drives.
- R6: Whenever output enable rises, the controller drives no lane in that cycle. A write therefore never follows a read without at least one undriven cycle with output enable high.
- R7: When a write is accepted in the final cycle of a previous write, write enable stays low without a break. Each word is framed only by its byte-enable pulse.
- R8: During a read, output enable and chip select are low, write enable is high and the byte enables follow the mask. `rsp_valid` is a one-cycle pulse RD_WAIT cycles after the accepting edge (3 at a 4 ns clock). `rsp_data` is sampled at the end of the access window.
- R9: In `rsp_data`, a lane not selected by the read mask reads as zero.
- R10: Whenever chip select is high, write enable, output enable and all byte enables are high, and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| ram_addr | output | 18 | RAM address |
| ram_dq_o | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 2 | Per-lane drive enable for ram_dq_o |
| ram_dq_i | input | 16 | Data from the RAM |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_be_n | output | 2 | RAM byte enables, bit 0 lower lane, active low |

## Verification
The cycle that holds the end of one write word is the same cycle that accepts the next request. A new write or a read can therefore start on the edge where the previous word's data hold ends. The bench provokes this by keeping `req_valid` high across streams of mixed requests, both in directed bursts and in a long random run. It also issues a write immediately after a read. A bench RAM model judges the outcome. It flags any cycle in which both sides drive, any byte-enable pulse shorter than the minimum and any data change inside a pulse. It also returns junk until the access time has elapsed. Read-back data, `req_ready` and `rsp_valid` are compared every cycle against a reference memory and a cycle-count model.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_WHOLD  = 3'd2,
    ST_RD     = 3'd3,
    ST_RTURN  = 3'd4
  } ctrl_state_t;

  // Round a duration up to whole clock cycles.
  function automatic int unsigned cyc_ceil(input int unsigned dur_ps,
                                           input int unsigned clk_ps);
    return (dur_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned RD_WAIT  = 3,
  parameter int unsigned WR_PULSE = 2,
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned CNT_W    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  output logic        req_ready,
  output logic        accept,
  output logic        capture,
  output ctrl_state_t state_d
);

  ctrl_state_t      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    capture   = 1'b0;
    req_ready = (state_q == ST_IDLE) || (state_q == ST_WHOLD);
    accept    = req_ready && req_valid;
    case (state_q)
      ST_IDLE, ST_WHOLD: begin
        if (accept) begin
          if (req_write) begin
            state_d = ST_WPULSE;
            cnt_d   = CNT_W'(WR_PULSE - 1);
          end else begin
            state_d = ST_RD;
            cnt_d   = CNT_W'(RD_WAIT - 1);
          end
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_WPULSE: begin
        if (cnt_q == '0) state_d = ST_WHOLD;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RD: begin
        if (cnt_q == '0) begin
          capture = 1'b1;
          state_d = ST_RTURN;
          cnt_d   = CNT_W'(TURN_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RTURN: begin
        if (cnt_q == '0) state_d = ST_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R2: an accepted request makes the port busy on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

endmodule

// File: rtl/sram_pin_drv.sv
module sram_pin_drv
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LANE_W   = 8,
  parameter int unsigned WR_PULSE = 2,
  localparam int unsigned LANES   = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_state_t       state_d,
  input  logic              accept,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic [LANES-1:0]  mask_q,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic [LANES-1:0]  ram_dq_oe,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [LANES-1:0]  ram_be_n
);

  logic [LANES-1:0] mask_d;
  logic             in_wr;
  logic             in_rd;
  logic             ce_n_d;
  logic             oe_n_d;
  logic             we_n_d;
  logic [LANES-1:0] be_n_d;
  logic [LANES-1:0] drv_d;

  always_comb begin
    mask_d = accept ? req_mask : mask_q;
    in_wr  = (state_d == ST_WPULSE) || (state_d == ST_WHOLD);
    in_rd  = (state_d == ST_RD);
    ce_n_d = !(in_wr || in_rd);
    we_n_d = !in_wr;
    oe_n_d = !in_rd;
    be_n_d = ((state_d == ST_WPULSE) || in_rd) ? ~mask_d : '1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_drv
    assign drv_d[l] = in_wr && mask_d[l];
  end

  // Strobes: every cycle. Request fields: clock-enabled by accept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_ce_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_be_n  <= '1;
      ram_dq_oe <= '0;
    end else begin
      ram_ce_n  <= ce_n_d;
      ram_oe_n  <= oe_n_d;
      ram_we_n  <= we_n_d;
      ram_be_n  <= be_n_d;
      ram_dq_oe <= drv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      ram_addr <= '0;
      ram_dq_o <= '0;
    end else if (accept) begin
      mask_q   <= req_mask;
      ram_addr <= req_addr;
      ram_dq_o <= req_wdata;
    end
  end

  // Checker state: length of the current write pulse.
  logic       wr_act;
  logic [7:0] pulse_len;
  assign wr_act = !ram_we_n && !ram_ce_n && (ram_be_n != '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pulse_len <= '0;
    else if (!wr_act)              pulse_len <= '0;
    else if (pulse_len != 8'hFF)   pulse_len <= pulse_len + 8'd1;
  end

  // R4: a write pulse lasts at least WR_PULSE cycles
  a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_act && $past(wr_act)) |-> (32'(pulse_len) >= WR_PULSE));

  // R5: drive only in a write with output enable high
  a_r5_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe != '0) |-> (ram_oe_n && !ram_we_n && !ram_ce_n));

  // R6: no drive in the cycle output enable rises
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> (ram_dq_oe == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R3: a lane being written is driven
    a_r3_lane_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (!ram_we_n && !ram_be_n[l]) |-> ram_dq_oe[l]);
    // R4: data held in the cycle after the enable rises
    a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ram_be_n[l]) && !ram_we_n) |->
        (ram_dq_oe[l] && $stable(ram_dq_o[l*LANE_W +: LANE_W])));
  end

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned LANES = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LANES-1:0]  mask_q,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= capture;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rsp_data[l*LANE_W +: LANE_W] <= '0;
      else if (capture)
        rsp_data[l*LANE_W +: LANE_W] <= mask_q[l] ? ram_dq_i[l*LANE_W +: LANE_W] : '0;
    end
  end

  // R8: read data strobe is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned CLK_PS    = 4000,
  parameter int unsigned T_ACC_PS  = 10000,
  parameter int unsigned T_PWE_PS  = 8000,
  parameter int unsigned T_SD_PS   = 6000,
  parameter int unsigned T_WC_PS   = 10000,
  parameter int unsigned TURN_CYC  = 1,
  localparam int unsigned LANES    = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic [LANES-1:0]  ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [LANES-1:0]  ram_be_n
);

  localparam int unsigned RD_WAIT  = umax(cyc_ceil(T_ACC_PS, CLK_PS), 1);
  localparam int unsigned WR_PULSE = umax(umax(cyc_ceil(T_PWE_PS, CLK_PS),
                                               cyc_ceil(T_SD_PS, CLK_PS)),
                                          umax(cyc_ceil(T_WC_PS, CLK_PS) - 1, 1));
  localparam int unsigned CNT_MAX  = umax(umax(RD_WAIT, WR_PULSE), TURN_CYC);
  localparam int unsigned CNT_W    = umax($clog2(CNT_MAX + 1), 1);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  ctrl_state_t      state_d;
  logic             accept;
  logic             capture;
  logic [LANES-1:0] mask_q;

  sram_seq_fsm #(
    .RD_WAIT (RD_WAIT),
    .WR_PULSE(WR_PULSE),
    .TURN_CYC(TURN_CYC),
    .CNT_W   (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .capture  (capture),
    .state_d  (state_d)
  );

  sram_pin_drv #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LANE_W  (LANE_W),
    .WR_PULSE(WR_PULSE)
  ) u_pins (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .state_d  (state_d),
    .accept   (accept),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .mask_q   (mask_q),
    .ram_addr (ram_addr),
    .ram_dq_o (ram_dq_o),
    .ram_dq_oe(ram_dq_oe),
    .ram_ce_n (ram_ce_n),
    .ram_oe_n (ram_oe_n),
    .ram_we_n (ram_we_n),
    .ram_be_n (ram_be_n)
  );

  sram_rd_capture #(
    .DATA_W(DATA_W),
    .LANE_W(LANE_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .capture  (capture),
    .mask_q   (mask_q),
    .ram_dq_i (ram_dq_i),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  // R2: accepted request selects the RAM on the next cycle
  a_r2_select_on_accept: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_ready) |=> !ram_ce_n);

  // R7: write accepted during a write keeps write enable low
  a_r7_we_held: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_ready && req_write && !ram_we_n) |=> (!ram_we_n && ram_oe_n));

  // R10: deselected means all strobes inactive and bus free
  a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_core_n)
    ram_ce_n |-> (ram_we_n && ram_oe_n && (&ram_be_n) && (ram_dq_oe == '0)));

endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [17:0] ram_addr;
  logic [15:0] ram_dq_o;
  logic [1:0]  ram_dq_oe;
  logic [15:0] ram_dq_i;
  logic        ram_ce_n;
  logic        ram_oe_n;
  logic        ram_we_n;
  logic [1:0]  ram_be_n;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe),
    .ram_dq_i(ram_dq_i), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .ram_we_n(ram_we_n), .ram_be_n(ram_be_n)
  );

  // 250 MHz
  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam int RD_LAT   = 3;  // cycles, 10 ns / 4 ns rounded up
  localparam int WR_RDY   = 2;
  localparam int RD_RDY   = 4;
  localparam int MIN_PULSE = 2; // 8 ns / 4 ns

  int n_cmp = 0;
  int n_bad = 0;
  bit run   = 0;
  bit done  = 0;
  int cyc   = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- RAM model -----------------
  logic [15:0] mem     [int];
  logic [15:0] ref_mem [int];
  logic [27:0] last_key;
  int          settle;
  int          wr_run;
  logic [15:0] prev_dq;
  logic        prev_oe_n;
  logic        prev_we_n;
  int          we_rises;

  function automatic logic [15:0] mem_rd(input int a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction
  function automatic logic [15:0] ref_rd(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
  endfunction

  initial begin
    ram_dq_i  = '0;
    last_key  = '0;
    settle    = 0;
    wr_run    = 0;
    prev_dq   = '0;
    prev_oe_n = 1'b1;
    prev_we_n = 1'b1;
    we_rises  = 0;
  end

  always @(negedge clk) begin
    logic [27:0] key;
    logic [15:0] w;
    logic        ram_drv;
    int          a;
    key = {ram_addr, ram_ce_n, ram_oe_n, ram_we_n, ram_be_n, ram_dq_oe[0], 2'b00};
    key[1:0] = 2'b00;
    a = int'(ram_addr);
    if (key != last_key) settle = 0; else settle++;
    last_key = key;
    ram_drv = !ram_ce_n && !ram_oe_n && ram_we_n && (ram_be_n != 2'b11);
    // R5: never both sides on the bus
    if (ram_drv && ram_dq_oe != 2'b00) chk("R5 contention", 1, 0);
    // R6: no drive directly after output enable was low
    if (ram_dq_oe != 2'b00 && !prev_oe_n) chk("R6 turnaround", 1, 0);
    // write side
    if (!ram_ce_n && !ram_we_n && ram_be_n != 2'b11) begin
      w = mem_rd(a);
      for (int l = 0; l < 2; l++) begin
        if (!ram_be_n[l]) begin
          if (!ram_dq_oe[l]) chk("R3 lane undriven in write", 1, 0);
          w[l*8 +: 8] = ram_dq_o[l*8 +: 8];
        end
      end
      mem[a] = w;
      if (wr_run > 0 && ram_dq_o !== prev_dq) chk("R4 data changed in pulse", ram_dq_o, prev_dq);
      wr_run++;
    end else if (wr_run > 0) begin
      chk("R4 pulse length", (wr_run >= MIN_PULSE), 1);
      wr_run = 0;
    end
    prev_dq = ram_dq_o;
    if (ram_we_n && !prev_we_n) we_rises++;
    prev_we_n = ram_we_n;
    prev_oe_n = ram_oe_n;
    // read side: junk until access time has elapsed
    w = '0;
    if (ram_drv) begin
      for (int l = 0; l < 2; l++)
        if (!ram_be_n[l])
          w[l*8 +: 8] = (settle >= 2) ? mem_rd(a) >> (l*8) : 8'hA5;
    end
    ram_dq_i = w;
  end

  // ---------------- reference model -----------------
  int          due_q [$];
  logic [15:0] dat_q [$];
  int          ready_at = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    bit          exp_v;
    logic [15:0] e;
    if (run) begin
      exp_v = (due_q.size() > 0) && (due_q[0] == cyc);
      chk("R8 rsp_valid timing", rsp_valid, exp_v);
      if (exp_v) begin
        chk("R8/R9 read data", rsp_data, dat_q[0]);
        void'(due_q.pop_front());
        void'(dat_q.pop_front());
      end
      chk("R2 ready", req_ready, (cyc >= ready_at));
      if (ram_ce_n) chk("R10 deselect", {ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe}, 6'b111100);
      if (!ram_oe_n) chk("R8 read strobes", {ram_we_n, ram_ce_n}, 2'b10);
      if (req_valid && req_ready) begin
        if (req_write) begin
          e = ref_rd(int'(req_addr));
          for (int l = 0; l < 2; l++)
            if (req_mask[l]) e[l*8 +: 8] = req_wdata[l*8 +: 8];
          ref_mem[int'(req_addr)] = e;
          ready_at = cyc + 1 + WR_RDY;
        end else begin
          e = ref_rd(int'(req_addr));
          for (int l = 0; l < 2; l++)
            if (!req_mask[l]) e[l*8 +: 8] = 8'h00;
          due_q.push_back(cyc + 1 + RD_LAT);
          dat_q.push_back(e);
          ready_at = cyc + 1 + RD_RDY;
        end
      end
    end
  end

  // ---------------- stimulus -----------------
  task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    bit acc;
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_wdata = d;
    req_mask  = m;
    acc = 0;
    while (!acc) begin
      @(negedge clk);
      acc = req_ready;
      @(posedge clk);
      #1;
    end
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int rises0;
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0; req_mask = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 strobes in reset", {ram_ce_n, ram_oe_n, ram_we_n, ram_be_n}, 5'b11111);
    chk("R1 no drive in reset", ram_dq_oe, 2'b00);
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (4) @(posedge clk); #1;
    @(negedge clk);
    chk("R1 ready after reset", req_ready, 1);
    chk("R1 strobes after reset", {ram_ce_n, ram_oe_n, ram_we_n, ram_be_n}, 5'b11111);
    @(posedge clk); #1;
    run = 1;

    // full word write and read back
    issue(1, 18'h00010, 16'h1234, 2'b11);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    idle(6);
    // R3: lane writes
    issue(1, 18'h00010, 16'hAB99, 2'b01);
    issue(1, 18'h00010, 16'hCD77, 2'b10);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    idle(6);
    // R9: partial-mask reads
    issue(0, 18'h00010, 16'h0000, 2'b01);
    issue(0, 18'h00010, 16'h0000, 2'b10);
    idle(6);
    // R3: empty mask leaves memory unchanged
    issue(1, 18'h00010, 16'hFFFF, 2'b00);
    issue(0, 18'h00010, 16'h0000, 2'b11);
    idle(6);
    // R7: back-to-back write burst keeps write enable low
    rises0 = we_rises;
    for (int i = 0; i < 4; i++) issue(1, 18'h00100 + 18'(i), 16'h5000 + 16'(i * 16'h0111), 2'b11);
    idle(4);
    chk("R7 single write-enable rise over burst", we_rises - rises0, 1);
    for (int i = 0; i < 4; i++) issue(0, 18'h00100 + 18'(i), 16'h0, 2'b11);
    idle(6);
    // R6: write right after read, read right after write
    issue(0, 18'h00101, 16'h0, 2'b11);
    issue(1, 18'h00101, 16'hBEEF, 2'b11);
    issue(0, 18'h00101, 16'h0, 2'b11);
    idle(6);
    // address boundaries
    issue(1, 18'h00000, 16'h0F0F, 2'b11);
    issue(1, 18'h3FFFF, 16'hF00D, 2'b11);
    issue(0, 18'h3FFFF, 16'h0, 2'b11);
    issue(0, 18'h00000, 16'h0, 2'b11);
    idle(6);
    // random mixed stream
    for (int i = 0; i < 400; i++) begin
      issue(1'($urandom_range(0, 1)), 18'($urandom_range(0, 15)),
            16'($urandom_range(0, 65535)), 2'($urandom_range(0, 3)));
      if ($urandom_range(0, 7) == 0) idle(1 + $urandom_range(0, 3));
    end
    idle(10);
    chk("R8 all reads answered", due_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule